// File: doc/BRIEF.md
# Receive VLAN Tag Filter

This block watches one received Ethernet frame at a time, delivered as a byte stream that starts with the first destination-address byte. It looks at the Length/Type field to decide whether the frame carries an 802.1Q tag. It then compares the tag that follows with a programmed tag value, either the full 16 bits or only the 12-bit VLAN identifier. It also counts the frame's bytes. When the last byte arrives, it reports a VLAN flag, a tag-match bit and an oversize flag. The oversize limit is higher when the frame is tagged.

The byte input is a valid/ready stream. The block never applies back-pressure: `s_ready` goes high on the first clock after reset is released and stays high. A byte is taken on every cycle where `s_valid` and `s_ready` are both high. Upstream may drop `s_valid` for any number of cycles inside a frame. The tag value and the 12-bit-mode select are plain control inputs. They are captured on the start-of-frame byte. The status outputs are a plain one-cycle report and have no handshake.

Top module: `vlan_rx_filter`

## Requirements
- R1: `s_ready` is low while reset is asserted and high from the first clock edge after release. A byte is taken only when `s_valid` is high. Cycles with `s_valid` low change nothing.
- R2: A frame is a VLAN frame when its byte 13 is 0x81 and its byte 14 is 0x00. Bytes are counted from 1 at the start-of-frame byte, and multi-byte fields arrive most significant byte first. Such a frame raises `st_vlan` in its report.
- R3: With `cfg_vid_only` low, `st_match` needs the 16-bit value {byte 15, byte 16} to equal `cfg_tag` in all 16 bits.
- R4: With `cfg_vid_only` high, only bits 11:0 (the VLAN identifier) of {byte 15, byte 16} and of `cfg_tag` are compared. Bits 15:12 (priority in 15:13, format indicator in 12) are ignored.
- R5: When the compared part of `cfg_tag` is zero, no tag comparison is made and every VLAN frame reports `st_match` high.
- R6: `st_match` is never high unless `st_vlan` is high in the same report.
- R7: `st_oversize` is high when the frame's byte count exceeds 1518 for an untagged frame, or 1522 for a VLAN frame.
- R8: A frame that ends before its 16th byte never reports `st_vlan` or `st_match`, whatever its bytes 13 and 14 hold.
- R9: `cfg_tag` and `cfg_vid_only` are sampled on the start-of-frame byte. Later changes do not affect that frame's report.
- R10: `st_valid` is high for exactly one cycle, the cycle after an accepted end-of-frame byte. Outside that cycle `st_vlan`, `st_match` and `st_oversize` are all low.
- R11: A byte with `s_sof` low that arrives while no frame is open is dropped. A start-of-frame byte inside an open frame abandons that frame and starts a new one.
- R12: On reset, all status outputs are low and the captured tag and mode are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte present |
| s_ready | output | 1 | Byte may be taken (high after reset) |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| s_data | input | 8 | Frame byte |
| cfg_tag | input | 16 | Programmed tag value |
| cfg_vid_only | input | 1 | Compare only bits 11:0 of the tag |
| st_valid | output | 1 | Frame report strobe |
| st_vlan | output | 1 | Frame is VLAN-tagged |
| st_match | output | 1 | Tag matched the programmed value |
| st_oversize | output | 1 | Frame longer than its legal limit |

## Verification
The assertions assume that `s_valid` is never high during reset. The report-strobe property relies on `s_eof` arriving only with a byte that the block takes. The stimulus drives bytes only after reset is released and raises `s_eof` only together with `s_valid`. The stray-byte and restart cases still do this. The bench also changes `cfg_tag` and `cfg_vid_only` only on the falling edge, so the value sampled on the start-of-frame byte is well defined.

// File: rtl/vlan_filt_pkg.sv
package vlan_filt_pkg;
  localparam logic [15:0] TPID_VLAN = 16'h8100;
  localparam int TYPE_HI_POS = 13;
  localparam int HDR_BYTES   = 4;
  localparam int TAG_LO_POS  = TYPE_HI_POS + HDR_BYTES - 1;

  typedef struct packed {
    logic vlan;
    logic match;
    logic oversize;
  } vf_report_t;
endpackage

// File: rtl/vf_beat_track.sv
module vf_beat_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sof,
  input  logic             eof,
  output logic             start,
  output logic             beat_ok,
  output logic             end_ok,
  output logic [CNT_W-1:0] idx_cur
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cont;

  always_comb begin
    start   = take & sof;
    cont    = take & ~sof & open_q;
    beat_ok = start | cont;
    end_ok  = beat_ok & eof;
    if (start)
      idx_cur = CNT_W'(1);
    else if (cnt_q == CNT_MAX)
      idx_cur = CNT_MAX;
    else
      idx_cur = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (beat_ok)
        cnt_q <= idx_cur;
      if (end_ok)
        open_q <= 1'b0;
      else if (start)
        open_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vf_hdr_capture.sv
module vf_hdr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_ok,
  input  logic [CNT_W-1:0] idx_cur,
  input  logic [7:0]       data,
  output logic [15:0]      type_nx,
  output logic [15:0]      tag_nx
);
  import vlan_filt_pkg::*;

  logic [7:0] slot_nx [HDR_BYTES];

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_slot
    logic [7:0] slot_q;
    logic       hit;
    assign hit        = beat_ok && (idx_cur == CNT_W'(TYPE_HI_POS + k));
    assign slot_nx[k] = hit ? data : slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (hit)
        slot_q <= data;
    end
  end

  assign type_nx = {slot_nx[0], slot_nx[1]};
  assign tag_nx  = {slot_nx[2], slot_nx[3]};
endmodule

// File: rtl/vf_cfg_hold.sv
module vf_cfg_hold #(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] cfg_tag,
  input  logic             cfg_vid_only,
  output logic [TAG_W-1:0] eff_tag,
  output logic             eff_vid_only
);
  logic [TAG_W-1:0] tag_q;
  logic             mode_q;

  assign eff_tag      = start ? cfg_tag : tag_q;
  assign eff_vid_only = start ? cfg_vid_only : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      tag_q  <= cfg_tag;
      mode_q <= cfg_vid_only;
    end
  end
endmodule

// File: rtl/vf_decide.sv
module vf_decide #(
  parameter int CNT_W      = 16,
  parameter int TAG_W      = 16,
  parameter int VID_W      = 12,
  parameter int LEN_PLAIN  = 1518,
  parameter int LEN_TAGGED = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_ok,
  input  logic [CNT_W-1:0] idx_cur,
  input  logic [15:0]      type_nx,
  input  logic [TAG_W-1:0] tag_nx,
  input  logic [TAG_W-1:0] eff_tag,
  input  logic             eff_vid_only,
  output logic             st_valid,
  output vlan_filt_pkg::vf_report_t st_rep
);
  import vlan_filt_pkg::*;

  localparam logic [TAG_W-1:0] MASK_FULL = {TAG_W{1'b1}};
  localparam logic [TAG_W-1:0] MASK_VID  = TAG_W'({VID_W{1'b1}});

  logic [TAG_W-1:0] mask, want, got;
  logic             long_enough, is_tag, wild, eq;
  logic [CNT_W-1:0] limit;
  vf_report_t       rep_nx;

  always_comb begin
    mask        = eff_vid_only ? MASK_VID : MASK_FULL;
    want        = eff_tag & mask;
    got         = tag_nx & mask;
    long_enough = idx_cur >= CNT_W'(TAG_LO_POS);
    is_tag      = long_enough && (type_nx == TPID_VLAN);
    wild        = (want == '0);
    eq          = (got == want);
    limit       = is_tag ? CNT_W'(LEN_TAGGED) : CNT_W'(LEN_PLAIN);
    rep_nx.vlan     = is_tag;
    rep_nx.match    = is_tag && (wild || eq);
    rep_nx.oversize = idx_cur > limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_rep   <= '0;
    end else begin
      st_valid <= end_ok;
      st_rep   <= end_ok ? rep_nx : '0;
    end
  end
endmodule

// File: rtl/vlan_rx_filter.sv
module vlan_rx_filter #(
  parameter int CNT_W      = 16,
  parameter int TAG_W      = 16,
  parameter int VID_W      = 12,
  parameter int LEN_PLAIN  = 1518,
  parameter int LEN_TAGGED = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sof,
  input  logic             s_eof,
  input  logic [7:0]       s_data,
  input  logic [TAG_W-1:0] cfg_tag,
  input  logic             cfg_vid_only,
  output logic             st_valid,
  output logic             st_vlan,
  output logic             st_match,
  output logic             st_oversize
);
  import vlan_filt_pkg::*;

  logic             rdy_q, take, start, beat_ok, end_ok, eff_vid_only;
  logic [CNT_W-1:0] idx_cur;
  logic [15:0]      type_nx, tag_nx;
  logic [TAG_W-1:0] eff_tag;
  vf_report_t       rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign s_ready = rdy_q;
  assign take    = s_valid & rdy_q;

  vf_beat_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(s_sof), .eof(s_eof),
    .start(start), .beat_ok(beat_ok), .end_ok(end_ok), .idx_cur(idx_cur)
  );

  vf_hdr_capture #(.CNT_W(CNT_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .beat_ok(beat_ok), .idx_cur(idx_cur),
    .data(s_data), .type_nx(type_nx), .tag_nx(tag_nx)
  );

  vf_cfg_hold #(.TAG_W(TAG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_tag(cfg_tag),
    .cfg_vid_only(cfg_vid_only), .eff_tag(eff_tag), .eff_vid_only(eff_vid_only)
  );

  vf_decide #(
    .CNT_W(CNT_W), .TAG_W(TAG_W), .VID_W(VID_W),
    .LEN_PLAIN(LEN_PLAIN), .LEN_TAGGED(LEN_TAGGED)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .end_ok(end_ok), .idx_cur(idx_cur),
    .type_nx(type_nx), .tag_nx(TAG_W'(tag_nx)), .eff_tag(eff_tag),
    .eff_vid_only(eff_vid_only), .st_valid(st_valid), .st_rep(rep)
  );

  assign st_vlan     = rep.vlan;
  assign st_match    = rep.match;
  assign st_oversize = rep.oversize;
endmodule

// File: rtl/vf_checker.sv
module vf_checker (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_eof,
  input logic s_ready,
  input logic st_valid,
  input logic st_vlan,
  input logic st_match,
  input logic st_oversize
);
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);

  a_r6_match_needs_vlan: assert property (@(posedge clk) disable iff (!rst_n)
    st_match |-> st_vlan);

  a_r10_strobe_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(s_valid && s_eof));

  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (!st_vlan && !st_match && !st_oversize));
endmodule

bind vlan_rx_filter vf_checker u_vf_checker (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_eof(s_eof),
  .s_ready(s_ready), .st_valid(st_valid), .st_vlan(st_vlan),
  .st_match(st_match), .st_oversize(st_oversize)
);

// File: tb/tb_vlan_rx_filter.sv
module tb_vlan_rx_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0] s_data = '0;
  logic [15:0] cfg_tag = '0;
  logic cfg_vid_only = 1'b0;
  logic s_ready, st_valid, st_vlan, st_match, st_oversize;

  always #2.5 clk = ~clk;

  vlan_rx_filter dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sof(s_sof), .s_eof(s_eof), .s_data(s_data), .cfg_tag(cfg_tag),
    .cfg_vid_only(cfg_vid_only), .st_valid(st_valid), .st_vlan(st_vlan),
    .st_match(st_match), .st_oversize(st_oversize)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R12";
  bit done = 0;

  // reference model: byte queue per open frame
  byte unsigned fq[$];
  bit m_open = 0;
  logic [15:0] m_tag = '0;
  bit m_vid = 0;
  bit e_ready = 0, e_valid = 0, e_vlan = 0, e_match = 0, e_over = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq.delete(); m_open = 0; m_tag = '0; m_vid = 0;
      e_ready <= 0; e_valid <= 0; e_vlan <= 0; e_match <= 0; e_over <= 0;
    end else begin
      e_ready <= 1;
      e_valid <= 0; e_vlan <= 0; e_match <= 0; e_over <= 0;
      if (s_valid && e_ready) begin
        if (s_sof) begin
          fq.delete(); m_open = 1; m_tag = cfg_tag; m_vid = cfg_vid_only;
        end
        if (m_open) begin
          fq.push_back(s_data);
          if (s_eof) begin
            int n;
            bit v;
            logic [15:0] msk, tg;
            n = fq.size();
            v = (n >= 16) && fq[12] == 8'h81 && fq[13] == 8'h00;
            msk = m_vid ? 16'h0FFF : 16'hFFFF;
            tg = (n >= 16) ? {fq[14], fq[15]} : 16'h0;
            e_valid <= 1;
            e_vlan <= v;
            e_match <= v && (((m_tag & msk) == 0) || ((tg & msk) == (m_tag & msk)));
            e_over <= n > (v ? 1522 : 1518);
            m_open = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if ({s_ready, st_valid, st_vlan, st_match, st_oversize} !==
          {e_ready, e_valid, e_vlan, e_match, e_over}) begin
        miscompares++;
        $display("FAIL %s t=%0t ready/valid/vlan/match/over actual=%b%b%b%b%b expected=%b%b%b%b%b",
                 cur_req, $time, s_ready, st_valid, st_vlan, st_match, st_oversize,
                 e_ready, e_valid, e_vlan, e_match, e_over);
      end
    end
  end

  task automatic beat(input logic sof, input logic eof, input logic [7:0] d);
    @(negedge clk);
    s_valid = 1; s_sof = sof; s_eof = eof; s_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 0; s_sof = 0; s_eof = 0; s_data = 8'hxx === 8'h0 ? 8'h0 : 8'h5A;
    end
  endtask

  // byte i (1-based): 13..14 type, 15..16 tag, others pattern
  task automatic send_frame(input int len, input logic [15:0] ty, input logic [15:0] tg,
                            input int gap_every, input int chg_at,
                            input logic [15:0] chg_tag, input logic chg_mode);
    for (int i = 1; i <= len; i++) begin
      logic [7:0] d;
      case (i)
        13: d = ty[15:8];
        14: d = ty[7:0];
        15: d = tg[15:8];
        16: d = tg[7:0];
        default: d = 8'(i * 7 + 3);
      endcase
      beat(i == 1, i == len, d);
      if (i == chg_at) begin cfg_tag = chg_tag; cfg_vid_only = chg_mode; end
      if (gap_every > 0 && (i % gap_every) == 0 && i != len) idle(2);
    end
    idle(3);
  endtask

  task automatic frame(input int len, input logic [15:0] ty, input logic [15:0] tg);
    send_frame(len, ty, tg, 0, 0, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    cur_req = "R1";
    @(negedge clk) rst_n = 1;
    idle(3);
    cur_req = "R2"; cfg_tag = 16'h0; cfg_vid_only = 0;
    frame(64, 16'h0800, 16'h1234);
    frame(64, 16'h8100, 16'h1234);
    frame(60, 16'h8101, 16'h1234);
    cur_req = "R5"; frame(64, 16'h8100, 16'hFFFF);
    cur_req = "R3"; cfg_tag = 16'h6123;
    frame(64, 16'h8100, 16'h6123);
    frame(64, 16'h8100, 16'h7123);
    frame(64, 16'h8100, 16'h6122);
    cur_req = "R6"; frame(64, 16'h0800, 16'h6123);
    cur_req = "R4"; cfg_vid_only = 1; cfg_tag = 16'h0123;
    frame(64, 16'h8100, 16'hE123);
    frame(64, 16'h8100, 16'hE124);
    cfg_tag = 16'hA123; frame(64, 16'h8100, 16'h0123);
    cur_req = "R5"; cfg_tag = 16'hF000;
    frame(64, 16'h8100, 16'h0ABC);
    cur_req = "R8"; cfg_tag = 16'h0; cfg_vid_only = 0;
    frame(15, 16'h8100, 16'h0000);
    frame(14, 16'h8100, 16'h0000);
    frame(1, 16'h8100, 16'h0000);
    frame(16, 16'h8100, 16'h0000);
    cur_req = "R7";
    frame(1518, 16'h0800, 16'h0);
    frame(1519, 16'h0800, 16'h0);
    frame(1522, 16'h8100, 16'h0);
    frame(1523, 16'h8100, 16'h0);
    frame(1520, 16'h8100, 16'h0);
    cur_req = "R9"; cfg_tag = 16'h0456; cfg_vid_only = 0;
    send_frame(64, 16'h8100, 16'h0456, 0, 5, 16'h0999, 1'b1);
    cfg_tag = 16'h0456; cfg_vid_only = 1;
    send_frame(64, 16'h8100, 16'hF456, 0, 3, 16'h0000, 1'b0);
    cur_req = "R11"; cfg_tag = 16'h0321; cfg_vid_only = 0;
    send_frame(40, 16'h8100, 16'h0321, 3, 0, 16'h0, 1'b0);
    beat(0, 0, 8'h11); beat(0, 1, 8'h22); idle(3);
    for (int i = 1; i <= 20; i++) beat(i == 1, 0, 8'h81);
    frame(30, 16'h8100, 16'h0321);
    cur_req = "R10";
    beat(1, 1, 8'h00); beat(1, 1, 8'h01); idle(3);
    cur_req = "R12";
    @(negedge clk) rst_n = 0;
    idle(3);
    @(negedge clk) rst_n = 1;
    cfg_tag = 16'h0321;
    frame(20, 16'h8100, 16'h0321);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule